// File: doc/BRIEF.md
# Windowed Conversion Result Monitor

This block sits beside a converter and checks each finished result against a programmable window. A window has an upper and a lower limit, each as wide as a result. When a monitored channel produces a value above the upper limit or below the lower limit, the block latches a status bit for that channel. It also latches one combined event flag. The event flag drives an interrupt line through a mask bit.

The converter presents a one-cycle valid strobe together with the channel number and the result value. Software programs the limits, the per-channel enables and the interrupt mask through a simple write port. The same port clears the latched status bits and the event flag. The block samples its reset asynchronously and releases it in step with the clock.

Top module: `win_watch`

## Requirements
- R1: After reset, all channel status bits, the event flag and the interrupt are 0. The upper limit resets to all ones and the lower limit to zero, so no result can raise an event until the limits are changed.
- R2: A valid result on an enabled channel that is strictly greater than the upper limit sets that channel's status bit and the event flag on the clock edge that samples the strobe.
- R3: A valid result on an enabled channel that is strictly less than the lower limit sets that channel's status bit and the event flag on the same edge.
- R4: A result equal to either limit, or lying between them, sets nothing.
- R5: A result on a channel whose enable bit (write address 2, bit n for channel n) is 0 never sets a status bit or the event flag.
- R6: Status bits hold until cleared. Writing to address 3 clears exactly the status bits whose data bits are 1 and leaves the others and the event flag unchanged.
- R7: The event flag holds until a write to address 4 with data bit 1 set clears it. That write leaves the status bits unchanged.
- R8: The interrupt output equals the event flag ANDed with the mask bit, which is data bit 0 of every write to address 4. It follows the mask on the edge after the write.
- R9: If a new out-of-window result arrives on the same edge as a clear of its status bit or of the event flag, the new event wins and the bit stays 1.
- R10: A result whose channel number is NUM_CH or above is ignored.
- R11: Channel number and data are ignored while the valid strobe is low. Writes to address 0 load the upper limit and writes to address 1 load the lower limit, from the low DATA_W bits of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a finished result |
| res_ch | input | CH_W (4) | Channel number of the result |
| res_data | input | DATA_W (10) | Result value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 upper, 1 lower, 2 enables, 3 status clear, 4 control |
| wr_data | input | REG_W (10) | Register write data |
| ch_status | output | NUM_CH (10) | Latched per-channel out-of-window bits |
| evt_flag | output | 1 | Latched combined event flag |
| irq | output | 1 | Masked watchdog interrupt |

## Verification
Every internal register of this block reaches a port within one edge. A wrong limit, enable or mask bit shows up at `ch_status`, `evt_flag` or `irq` on the edge that samples the first result or write depending on it. A status bit that sets or clears on its own is visible at the port the cycle it happens, and stays visible until the next clear because the bits are sticky. For this reason every driven cycle is compared against a reference model. The bench probes each limit value, the values equal to it and one step past it, as well as a set and a clear arriving on the same edge.

// File: rtl/win_watch_pkg.sv
package win_watch_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_UPPER    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOWER    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CHAN_EN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT_CLR = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd4;

  localparam int CTRL_MASK_BIT  = 0;
  localparam int CTRL_EVCLR_BIT = 1;
endpackage

// File: rtl/win_watch_rst_sync.sv
module win_watch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/win_watch_regs.sv
module win_watch_regs
  import win_watch_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 10,
  localparam int REG_W = (DATA_W > NUM_CH) ? DATA_W : NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [DATA_W-1:0] upper_thr,
  output logic [DATA_W-1:0] lower_thr,
  output logic [NUM_CH-1:0] chan_en,
  output logic              irq_mask,
  output logic [NUM_CH-1:0] clr_mask,
  output logic              evt_clr
);
  logic [DATA_W-1:0] upper_q, upper_d;
  logic [DATA_W-1:0] lower_q, lower_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              mask_q, mask_d;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    upper_d  = upper_q;
    lower_d  = lower_q;
    en_d     = en_q;
    mask_d   = mask_q;
    clr_mask = '0;
    evt_clr  = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        ADDR_UPPER:    upper_d  = wr_data[DATA_W-1:0];
        ADDR_LOWER:    lower_d  = wr_data[DATA_W-1:0];
        ADDR_CHAN_EN:  en_d     = wr_data[NUM_CH-1:0];
        ADDR_STAT_CLR: clr_mask = wr_data[NUM_CH-1:0];
        ADDR_CTRL: begin
          mask_d  = wr_data[CTRL_MASK_BIT];
          evt_clr = wr_data[CTRL_EVCLR_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= {DATA_W{1'b1}};
      lower_q <= '0;
      en_q    <= '0;
      mask_q  <= 1'b0;
    end else if (wr_en) begin
      upper_q <= upper_d;
      lower_q <= lower_d;
      en_q    <= en_d;
      mask_q  <= mask_d;
    end
  end

  assign upper_thr = upper_q;
  assign lower_thr = lower_q;
  assign chan_en   = en_q;
  assign irq_mask  = mask_q;
endmodule

// File: rtl/win_watch_cmp.sv
module win_watch_cmp #(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 10,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] upper_thr,
  input  logic [DATA_W-1:0] lower_thr,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] hit_vec
);
  logic outside;

  always_comb begin
    outside = (res_data > upper_thr) || (res_data < lower_thr);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign hit_vec[i] = res_valid && outside && chan_en[i] &&
                        (res_ch == CH_W'(i));
  end
endmodule

// File: rtl/win_watch_flags.sv
module win_watch_flags #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_vec,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic              evt_clr,
  input  logic              irq_mask,
  output logic [NUM_CH-1:0] ch_status,
  output logic              evt_flag,
  output logic              irq
);
  logic [NUM_CH-1:0] stat_q, stat_d;
  logic              evt_q, evt_d;
  logic              any_hit;
  logic              upd_en;

  always_comb begin
    any_hit = |hit_vec;
    stat_d  = (stat_q & ~clr_mask) | hit_vec;
    evt_d   = (evt_q & ~evt_clr) | any_hit;
    upd_en  = any_hit || (|clr_mask) || evt_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      evt_q  <= 1'b0;
    end else if (upd_en) begin
      stat_q <= stat_d;
      evt_q  <= evt_d;
    end
  end

  assign ch_status = stat_q;
  assign evt_flag  = evt_q;
  assign irq       = evt_q & irq_mask;
endmodule

// File: rtl/win_watch.sv
module win_watch
  import win_watch_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 10,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int REG_W = (DATA_W > NUM_CH) ? DATA_W : NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [DATA_W-1:0] res_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] ch_status,
  output logic              evt_flag,
  output logic              irq
);
  logic              rst_n_int;
  logic [DATA_W-1:0] upper_thr;
  logic [DATA_W-1:0] lower_thr;
  logic [NUM_CH-1:0] chan_en;
  logic              irq_mask;
  logic [NUM_CH-1:0] clr_mask;
  logic              evt_clr;
  logic [NUM_CH-1:0] hit_vec;

  win_watch_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  win_watch_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .upper_thr (upper_thr),
    .lower_thr (lower_thr),
    .chan_en   (chan_en),
    .irq_mask  (irq_mask),
    .clr_mask  (clr_mask),
    .evt_clr   (evt_clr)
  );

  win_watch_cmp #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_cmp (
    .res_valid (res_valid),
    .res_ch    (res_ch),
    .res_data  (res_data),
    .upper_thr (upper_thr),
    .lower_thr (lower_thr),
    .chan_en   (chan_en),
    .hit_vec   (hit_vec)
  );

  win_watch_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .hit_vec   (hit_vec),
    .clr_mask  (clr_mask),
    .evt_clr   (evt_clr),
    .irq_mask  (irq_mask),
    .ch_status (ch_status),
    .evt_flag  (evt_flag),
    .irq       (irq)
  );
endmodule

// File: rtl/win_watch_chk.sv
module win_watch_chk
  import win_watch_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 10,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int REG_W = (DATA_W > NUM_CH) ? DATA_W : NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [CH_W-1:0]   res_ch,
  input logic [DATA_W-1:0] res_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic [NUM_CH-1:0] ch_status,
  input logic              evt_flag,
  input logic              irq,
  input logic              irq_mask
);
  logic unused_chk;
  assign unused_chk = ^res_data;

  // R2 R3 R11: a status bit only rises after a valid result strobe
  p_set_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_status & ~$past(ch_status))) |-> $past(res_valid));

  // R2 R10: a newly set bit belongs to the channel that was presented
  p_set_matches_ch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_status & ~$past(ch_status) & ~(NUM_CH'(1) << $past(res_ch))) == '0));

  // R6: status bits fall only after a write to the clear address
  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ch_status) & ~ch_status)) |->
      $past(wr_en && (wr_addr == ADDR_STAT_CLR)));

  // R7: event flag falls only after a control write with the clear bit
  p_evt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_flag) |->
      $past(wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_EVCLR_BIT]));

  // R2 R3: a rising event flag comes with a status bit set
  p_evt_has_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> ($countones(ch_status) > 0));

  // R8: the interrupt needs both the flag and the mask
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flag && irq_mask));
endmodule

bind win_watch win_watch_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_ch    (res_ch),
  .res_data  (res_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ch_status (ch_status),
  .evt_flag  (evt_flag),
  .irq       (irq),
  .irq_mask  (irq_mask)
);

// File: tb/tb_win_watch.sv
module tb_win_watch;
  import win_watch_pkg::*;

  localparam int DATA_W = 10;
  localparam int NUM_CH = 10;
  localparam int CH_W   = 4;
  localparam int REG_W  = 10;

  typedef struct {
    logic [NUM_CH-1:0] status;
    logic              evt;
    logic              irq;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              res_valid;
  logic [CH_W-1:0]   res_ch;
  logic [DATA_W-1:0] res_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [REG_W-1:0]  wr_data;
  logic [NUM_CH-1:0] ch_status;
  logic              evt_flag;
  logic              irq;

  int n_checks = 0;
  int n_fails  = 0;
  exp_t sb_q[$];

  logic [NUM_CH-1:0] m_status = '0;
  logic              m_evt    = 1'b0;
  logic              m_mask   = 1'b0;
  logic [DATA_W-1:0] m_upper  = '1;
  logic [DATA_W-1:0] m_lower  = '0;
  logic [NUM_CH-1:0] m_en     = '0;

  always #2.5 clk = ~clk;

  win_watch dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
    .res_data(res_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch_status(ch_status), .evt_flag(evt_flag), .irq(irq)
  );

  task automatic drive(input logic v, input int ch, input int data,
                       input logic we, input int addr, input int wdata,
                       input string tag);
    logic [NUM_CH-1:0] set_v;
    logic [NUM_CH-1:0] clr_v;
    logic              eclr;
    exp_t              e;
    @(negedge clk);
    res_valid = v;
    res_ch    = CH_W'(ch);
    res_data  = DATA_W'(data);
    wr_en     = we;
    wr_addr   = ADDR_W'(addr);
    wr_data   = REG_W'(wdata);
    set_v = '0;
    if (v && ch < NUM_CH && m_en[ch] &&
        (DATA_W'(data) > m_upper || DATA_W'(data) < m_lower))
      set_v[ch] = 1'b1;
    clr_v = (we && addr == 3) ? NUM_CH'(wdata) : '0;
    eclr  = we && addr == 4 && wdata[1];
    m_status = (m_status & ~clr_v) | set_v;
    m_evt    = (m_evt & ~eclr) | (|set_v);
    if (we && addr == 4) m_mask  = wdata[0];
    if (we && addr == 0) m_upper = DATA_W'(wdata);
    if (we && addr == 1) m_lower = DATA_W'(wdata);
    if (we && addr == 2) m_en    = NUM_CH'(wdata);
    e.status = m_status;
    e.evt    = m_evt;
    e.irq    = m_evt & m_mask;
    e.tag    = tag;
    sb_q.push_back(e);
  endtask

  task automatic result(input int ch, input int data, input string tag);
    drive(1'b1, ch, data, 1'b0, 0, 0, tag);
  endtask

  task automatic wreg(input int addr, input int wdata, input string tag);
    drive(1'b0, 0, 0, 1'b1, addr, wdata, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (ch_status !== e.status || evt_flag !== e.evt || irq !== e.irq) begin
        n_fails++;
        $display("FAIL %s: got status=%h evt=%b irq=%b expected status=%h evt=%b irq=%b",
                 e.tag, ch_status, evt_flag, irq, e.status, e.evt, e.irq);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; res_valid = 1'b0; res_ch = '0; res_data = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (ch_status !== '0 || evt_flag !== 1'b0 || irq !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset: got status=%h evt=%b irq=%b expected 0 0 0",
               ch_status, evt_flag, irq);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: default limits never flag, even with everything enabled
    wreg(2, 10'h3FF, "R1 enable all");
    result(0, 10'h3FF, "R1 top value with default limits");
    result(1, 10'h000, "R1 bottom value with default limits");
    // R11: limit writes take effect
    wreg(0, 10'h200, "R11 load upper");
    wreg(1, 10'h100, "R11 load lower");
    // R4: boundaries and interior
    result(3, 10'h200, "R4 equal upper");
    result(4, 10'h100, "R4 equal lower");
    result(4, 10'h150, "R4 inside window");
    // R2 / R3
    result(2, 10'h201, "R2 one above upper");
    result(5, 10'h0FF, "R3 one below lower");
    // R8: mask behaviour
    wreg(4, 1, "R8 mask on");
    wreg(4, 0, "R8 mask off");
    wreg(4, 1, "R8 mask on again");
    // R6: selective clear, flag untouched
    wreg(3, 10'h004, "R6 clear ch2 only");
    drive(1'b0, 0, 0, 1'b0, 0, 0, "R6 sticky idle");
    // R7: clear event flag, status kept
    wreg(4, 3, "R7 clear event flag");
    // R5: disabled channel
    wreg(2, 10'h3BF, "R5 disable ch6");
    result(6, 10'h3FF, "R5 disabled channel out of window");
    // R10: channel number out of range
    result(12, 10'h3FF, "R10 channel out of range");
    // R11: strobe low ignores data
    drive(1'b0, 7, 10'h3FF, 1'b0, 0, 0, "R11 valid low");
    // R9: set beats clear on the same edge
    drive(1'b1, 7, 10'h3FF, 1'b1, 3, 10'h080, "R9 set vs status clear");
    drive(1'b1, 8, 10'h000, 1'b1, 4, 3, "R9 set vs event clear");
    // R3 at extreme lower bound, R2 at extreme upper
    wreg(3, 10'h3FF, "R6 clear all");
    result(9, 10'h3FF, "R2 max value");
    wreg(1, 10'h001, "R11 lower to 1");
    result(0, 10'h000, "R3 zero below lower 1");
    drive(1'b0, 0, 0, 1'b0, 0, 0, "final idle");
    while (sb_q.size() > 0) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule